// File: doc/BRIEF.md
# Sub-Second Timer with Synchronized Register Writes

This block is a two-stage timer that counts in a slow time base while its registers are written from a fast bus clock. A sub-second counter advances on each slow tick and wraps at a parameterised limit. A second counter advances each time the sub-second counter wraps. Each counter has a compare value. A match sets a pending flag, and the flags are masked onto one interrupt line. The slow time base is modelled as a clock-enable domain: `slow_tick` is a one-cycle pulse per slow period on the bus clock.

A bus write does not reach its register at once. The write is captured, a toggle request is carried through a two-stage synchronizer into the slow domain, and the value is applied there. An acknowledge toggle returns through a two-stage synchronizer on the bus side. Each synchronized register has its own busy flag that shows a transfer in flight. A second write to a register that is still busy is refused and raises a sticky error flag. Software clears that flag by writing to the status register.

Top module: `rtc_subsec_timer`

## Requirements
- R1: Register offsets are: 0x00 sub-second counter (15 bits), 0x04 second counter (32 bits), 0x08 sub-second compare (15 bits), 0x0C second compare (32 bits), 0x10 control (4 bits), 0x14 status, 0x18 interrupt clear. Counters and compare values read back zero-extended. The clear register reads 0.
- R2: A write to a synchronized register takes effect on the third `slow_tick` after the write cycle. Status bits 4..10 are busy flags for the sub-second counter, second counter, sub-second compare, second compare, control, sub-second clear and second clear, in that order. A busy flag is 1 from the cycle after the write until two clocks after the applying tick. Status bit 3 is 1 when any busy flag is 1.
- R3: A write whose target busy flag is already set leaves the register unchanged and sets status bit 2. Writes to other registers do not set bit 2.
- R4: Status bit 2 stays set until any write to offset 0x14, which clears it.
- R5: Control bit 0 enables sub-second counting and control bit 1 enables second counting. A disabled counter keeps its value. No counter changes without a `slow_tick`.
- R6: When counting is enabled, the sub-second counter goes from 32767 (parameter WRAP) to 0. On that wrap the second counter increments if control bit 1 is set.
- R7: On each `slow_tick`, the pending flag for a counter is set if that counter's value before the tick equals its compare value. Status bit 0 is the sub-second pending flag and status bit 1 is the second pending flag.
- R8: Writing 1 to clear bit 0 (or bit 1) clears the sub-second (or second) pending flag when the write is applied. The clear wins over a match on that same tick.
- R9: `irq` = (sub-second pending AND control bit 2) OR (second pending AND control bit 3).
- R10: After reset all registers, flags and `irq` are 0. Unmapped offsets read 0, and writes to them change nothing.
- R11: A counter write applied on a tick replaces that tick's count. A control change applied on a tick governs counting only from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all flops use it |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_tick | input | 1 | One-cycle enable marking a slow-domain step |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that `slow_tick`, `bus_wr` and `bus_addr` are known, single-driven values at every clock edge. They also assume that a tick arrives only as a clock-enable pulse, so the slow-domain flops move only on those cycles. The bench drives every input at the falling edge, holds `slow_tick` high for exactly one clock, and follows each tick with two idle clocks. Bus writes are never placed in a tick cycle. Random writes, including writes to busy registers, the status register and unmapped offsets, are mixed with random tick counts and compared against a bench model of the requirements.

// File: rtl/rtc_sync_pkg.sv
// Shared constants for the sub-second timer: bus offsets, transfer channel
// indices, control and status bit positions.
package rtc_sync_pkg;

    localparam int AW     = 5;
    localparam int DW     = 32;
    localparam int CTRL_W = 4;
    localparam int NUM_CH = 7;

    localparam logic [AW-1:0] OFS_SUB  = 5'h00;
    localparam logic [AW-1:0] OFS_SEC  = 5'h04;
    localparam logic [AW-1:0] OFS_ASUB = 5'h08;
    localparam logic [AW-1:0] OFS_ASEC = 5'h0C;
    localparam logic [AW-1:0] OFS_CTRL = 5'h10;
    localparam logic [AW-1:0] OFS_STAT = 5'h14;
    localparam logic [AW-1:0] OFS_CLR  = 5'h18;

    // Channel order equals the busy-bit order in the status word.
    localparam int CH_SUB  = 0;
    localparam int CH_SEC  = 1;
    localparam int CH_ASUB = 2;
    localparam int CH_ASEC = 3;
    localparam int CH_CTRL = 4;
    localparam int CH_CSUB = 5;
    localparam int CH_CSEC = 6;

    localparam int CB_SUB_EN  = 0;
    localparam int CB_SEC_EN  = 1;
    localparam int CB_IRQ_SUB = 2;
    localparam int CB_IRQ_SEC = 3;

    localparam int SB_ERR  = 2;
    localparam int SB_ANY  = 3;
    localparam int SB_BUSY = 4;

    // Payload width carried by each transfer channel.
    function automatic int chan_w(int ch, int sub_w, int sec_w);
        case (ch)
            CH_SUB, CH_ASUB: return sub_w;
            CH_SEC, CH_ASEC: return sec_w;
            CH_CTRL:         return CTRL_W;
            default:         return 1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_xfer_chan.sv
// One write-transfer channel. The bus side captures the data and flips a
// request toggle. The slow side (stepping only on slow_tick) passes the toggle
// through two flops and applies the held data when it differs from the last
// acknowledged value. The acknowledge toggle returns through two bus flops.
// Assumes start is raised only while busy is low, so the hold register stays
// stable during a transfer.
module rtc_xfer_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          start,
    input  logic [DW-1:0] din,
    output logic          busy,
    output logic          apply,
    output logic [DW-1:0] dout
);
    logic          req_q;
    logic [DW-1:0] hold_q;
    logic          s1_q, s2_q, ack_q;
    logic          a1_q, a2_q;

    // Bus side: latch the payload and flip the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (start) begin
            req_q  <= ~req_q;
            hold_q <= din;
        end
    end

    // Slow side: two-stage request synchronizer and acknowledge toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            ack_q <= 1'b0;
        end else if (slow_tick) begin
            s1_q  <= req_q;
            s2_q  <= s1_q;
            ack_q <= s2_q;
        end
    end

    // Bus side: two-stage acknowledge synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1_q <= 1'b0;
            a2_q <= 1'b0;
        end else begin
            a1_q <= ack_q;
            a2_q <= a1_q;
        end
    end

    assign apply = slow_tick & (s2_q ^ ack_q);
    assign busy  = req_q ^ a2_q;
    assign dout  = hold_q;

endmodule

// File: rtl/rtc_bus_regs.sv
// Bus front end: decodes writes into transfer starts, refuses writes that hit
// a busy channel and records them in a sticky error flag, and builds the
// combinational read word. Assumes a single write per cycle.
module rtc_bus_regs
    import rtc_sync_pkg::*;
#(
    parameter int SUB_W = 15,
    parameter int SEC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [1:0]        clr_bits,
    input  logic [NUM_CH-1:0] busy,
    input  logic [SUB_W-1:0]  sub_cnt,
    input  logic [SEC_W-1:0]  sec_cnt,
    input  logic [SUB_W-1:0]  sub_cmp,
    input  logic [SEC_W-1:0]  sec_cmp,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [1:0]        pend,
    output logic [NUM_CH-1:0] start,
    output logic              err,
    output logic [DW-1:0]     rdata
);
    logic [NUM_CH-1:0] want;
    logic              overlap;
    logic              stat_wr;

    // Map a write onto the channels it targets.
    always_comb begin
        want = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_SUB:  want[CH_SUB]  = 1'b1;
                OFS_SEC:  want[CH_SEC]  = 1'b1;
                OFS_ASUB: want[CH_ASUB] = 1'b1;
                OFS_ASEC: want[CH_ASEC] = 1'b1;
                OFS_CTRL: want[CH_CTRL] = 1'b1;
                OFS_CLR: begin
                    want[CH_CSUB] = clr_bits[0];
                    want[CH_CSEC] = clr_bits[1];
                end
                default: ;
            endcase
        end
    end

    assign overlap = |(want & busy);
    assign start   = want & ~busy;
    assign stat_wr = bus_wr && (bus_addr == OFS_STAT);

    // Sticky overlap error, cleared by any status write.
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (stat_wr) err <= 1'b0;
        else if (overlap) err <= 1'b1;
    end

    // Read word selection with zero extension.
    always_comb begin
        rdata = '0;
        case (bus_addr)
            OFS_SUB:  rdata[SUB_W-1:0]   = sub_cnt;
            OFS_SEC:  rdata[SEC_W-1:0]   = sec_cnt;
            OFS_ASUB: rdata[SUB_W-1:0]   = sub_cmp;
            OFS_ASEC: rdata[SEC_W-1:0]   = sec_cmp;
            OFS_CTRL: rdata[CTRL_W-1:0]  = ctrl;
            OFS_STAT: begin
                rdata[1:0]               = pend;
                rdata[SB_ERR]            = err;
                rdata[SB_ANY]            = |busy;
                rdata[SB_BUSY +: NUM_CH] = busy;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_count_core.sv
// Slow-domain state: both counters, both compare values, control and the
// pending flags. Everything moves only on slow_tick. An applied write
// overrides counting on its tick. Counting on a tick uses the control value
// held before that tick.
module rtc_count_core
    import rtc_sync_pkg::*;
#(
    parameter int SUB_W = 15,
    parameter int SEC_W = 32,
    parameter int WRAP  = 32767
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [NUM_CH-1:0] apply,
    input  logic [SUB_W-1:0]  d_sub,
    input  logic [SEC_W-1:0]  d_sec,
    input  logic [SUB_W-1:0]  d_sub_cmp,
    input  logic [SEC_W-1:0]  d_sec_cmp,
    input  logic [CTRL_W-1:0] d_ctrl,
    input  logic [1:0]        d_clr,
    output logic [SUB_W-1:0]  sub_cnt,
    output logic [SEC_W-1:0]  sec_cnt,
    output logic [SUB_W-1:0]  sub_cmp,
    output logic [SEC_W-1:0]  sec_cmp,
    output logic [CTRL_W-1:0] ctrl,
    output logic [1:0]        pend,
    output logic              irq
);
    localparam logic [SUB_W-1:0] WRAP_V = SUB_W'(WRAP);

    logic sub_top, sec_step, sub_hit, sec_hit;

    assign sub_top  = (sub_cnt >= WRAP_V);
    assign sec_step = ctrl[CB_SUB_EN] & ctrl[CB_SEC_EN] & sub_top;
    assign sub_hit  = (sub_cnt == sub_cmp);
    assign sec_hit  = (sec_cnt == sec_cmp);

    // Counter update: an applied write first, otherwise count if enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt <= '0;
            sec_cnt <= '0;
        end else if (slow_tick) begin
            if (apply[CH_SUB])          sub_cnt <= d_sub;
            else if (ctrl[CB_SUB_EN])   sub_cnt <= sub_top ? '0 : sub_cnt + 1'b1;
            if (apply[CH_SEC])          sec_cnt <= d_sec;
            else if (sec_step)          sec_cnt <= sec_cnt + 1'b1;
        end
    end

    // Compare values and control load from their transfer channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cmp <= '0;
            sec_cmp <= '0;
            ctrl    <= '0;
        end else begin
            if (apply[CH_ASUB]) sub_cmp <= d_sub_cmp;
            if (apply[CH_ASEC]) sec_cmp <= d_sec_cmp;
            if (apply[CH_CTRL]) ctrl    <= d_ctrl;
        end
    end

    // Pending flags: set on a compare match, cleared by an applied clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (slow_tick) begin
            pend[0] <= (apply[CH_CSUB] && d_clr[0]) ? 1'b0 : (pend[0] | sub_hit);
            pend[1] <= (apply[CH_CSEC] && d_clr[1]) ? 1'b0 : (pend[1] | sec_hit);
        end
    end

    assign irq = (pend[0] & ctrl[CB_IRQ_SUB]) | (pend[1] & ctrl[CB_IRQ_SEC]);

endmodule

// File: rtl/rtc_subsec_timer.sv
// Top level of the sub-second timer. It builds one transfer channel per
// synchronized register, then connects the bus front end and the slow-domain
// core. Assumes SUB_W and SEC_W do not exceed the bus width.
module rtc_subsec_timer
    import rtc_sync_pkg::*;
#(
    parameter int SUB_W = 15,
    parameter int SEC_W = 32,
    parameter int WRAP  = 32767
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic [NUM_CH-1:0] busy, start, apply;
    logic              err;
    logic [SUB_W-1:0]  sub_cnt, sub_cmp, d_sub, d_sub_cmp;
    logic [SEC_W-1:0]  sec_cnt, sec_cmp, d_sec, d_sec_cmp;
    logic [CTRL_W-1:0] ctrl, d_ctrl;
    logic [1:0]        pend, d_clr;

    // One transfer channel per synchronized register, sized to its payload.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        localparam int W = chan_w(g, SUB_W, SEC_W);
        logic [W-1:0] din_w, dout_w;
        if (g == CH_CSUB || g == CH_CSEC) begin : g_flag
            assign din_w = 1'b1;
        end else begin : g_data
            assign din_w = bus_wdata[W-1:0];
        end
        rtc_xfer_chan #(.DW(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .slow_tick (slow_tick),
            .start     (start[g]),
            .din       (din_w),
            .busy      (busy[g]),
            .apply     (apply[g]),
            .dout      (dout_w)
        );
    end

    assign d_sub     = g_chan[CH_SUB].dout_w;
    assign d_sec     = g_chan[CH_SEC].dout_w;
    assign d_sub_cmp = g_chan[CH_ASUB].dout_w;
    assign d_sec_cmp = g_chan[CH_ASEC].dout_w;
    assign d_ctrl    = g_chan[CH_CTRL].dout_w;
    assign d_clr     = {g_chan[CH_CSEC].dout_w, g_chan[CH_CSUB].dout_w};

    rtc_bus_regs #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .clr_bits (bus_wdata[1:0]),
        .busy     (busy),
        .sub_cnt  (sub_cnt),
        .sec_cnt  (sec_cnt),
        .sub_cmp  (sub_cmp),
        .sec_cmp  (sec_cmp),
        .ctrl     (ctrl),
        .pend     (pend),
        .start    (start),
        .err      (err),
        .rdata    (bus_rdata)
    );

    rtc_count_core #(.SUB_W(SUB_W), .SEC_W(SEC_W), .WRAP(WRAP)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .apply     (apply),
        .d_sub     (d_sub),
        .d_sec     (d_sec),
        .d_sub_cmp (d_sub_cmp),
        .d_sec_cmp (d_sec_cmp),
        .d_ctrl    (d_ctrl),
        .d_clr     (d_clr),
        .sub_cnt   (sub_cnt),
        .sec_cnt   (sec_cnt),
        .sub_cmp   (sub_cmp),
        .sec_cmp   (sec_cmp),
        .ctrl      (ctrl),
        .pend      (pend),
        .irq       (irq)
    );

endmodule

// File: rtl/rtc_sync_checker.sv
// Protocol and behaviour properties for the sub-second timer. The module is
// bound into the top level and observes its internal nets.
module rtc_sync_checker
    import rtc_sync_pkg::*;
#(
    parameter int SUB_W = 15,
    parameter int SEC_W = 32,
    parameter int WRAP  = 32767
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_tick,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic              irq,
    input logic [NUM_CH-1:0] busy,
    input logic [NUM_CH-1:0] apply,
    input logic              err,
    input logic [SUB_W-1:0]  sub_cnt,
    input logic [SEC_W-1:0]  sec_cnt,
    input logic [SUB_W-1:0]  sub_cmp,
    input logic [CTRL_W-1:0] ctrl,
    input logic [1:0]        pend
);
    localparam logic [SUB_W-1:0] WRAP_V = SUB_W'(WRAP);

    p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SUB && !busy[CH_SUB]) |=> busy[CH_SUB]);

    p_apply_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((apply & ~busy) == '0));

    p_overlap_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ASUB && busy[CH_ASUB]) |=> err);

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(bus_wr && bus_addr == OFS_STAT)) |=> err);

    p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STAT) |=> !err);

    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> ($stable(sub_cnt) && $stable(sec_cnt)));

    p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && !ctrl[CB_SUB_EN] && !apply[CH_SUB]) |=> $stable(sub_cnt));

    p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && ctrl[CB_SUB_EN] && !apply[CH_SUB] && sub_cnt == WRAP_V)
        |=> (sub_cnt == '0));

    p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && sub_cnt == sub_cmp && !apply[CH_CSUB]) |=> pend[0]);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_IRQ_SUB] && !ctrl[CB_IRQ_SEC]) |-> !irq);

endmodule

bind rtc_subsec_timer rtc_sync_checker #(.SUB_W(SUB_W), .SEC_W(SEC_W), .WRAP(WRAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq       (irq),
    .busy      (busy),
    .apply     (apply),
    .err       (err),
    .sub_cnt   (sub_cnt),
    .sec_cnt   (sec_cnt),
    .sub_cmp   (sub_cmp),
    .ctrl      (ctrl),
    .pend      (pend)
);

// File: tb/test_rtc_subsec_timer.sv
// Self-checking bench. A requirement-level model predicts every register and
// irq after each write and tick. Directed cases come first, then seeded
// random traffic.
module test_rtc_subsec_timer;
    import rtc_sync_pkg::*;

    localparam int SUB_W = 15;
    localparam int SEC_W = 32;
    localparam int WRAP  = 32767;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slow_tick = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;

    // Requirement model state.
    logic [SUB_W-1:0] m_sub, m_asub;
    logic [SEC_W-1:0] m_sec, m_asec;
    logic [3:0]       m_ctrl;
    logic [1:0]       m_pend;
    logic             m_err;
    int               m_left [NUM_CH];
    logic [31:0]      m_val  [NUM_CH];

    always #2 clk = ~clk;

    rtc_subsec_timer #(.SUB_W(SUB_W), .SEC_W(SEC_W), .WRAP(WRAP)) i_rtc_subsec_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = '0;
        s[1:0]   = m_pend;
        s[SB_ERR] = m_err;
        for (int i = 0; i < NUM_CH; i++) begin
            s[SB_BUSY + i] = (m_left[i] > 0);
            if (m_left[i] > 0) s[SB_ANY] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic exp_irq();
        return (m_pend[0] & m_ctrl[2]) | (m_pend[1] & m_ctrl[3]);
    endfunction

    task automatic model_take(int ch, logic [31:0] v);
        if (m_left[ch] > 0) m_err = 1'b1;
        else begin
            m_left[ch] = 3;
            m_val[ch]  = v;
        end
    endtask

    task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
        case (a)
            OFS_SUB:  model_take(CH_SUB,  {17'd0, d[SUB_W-1:0]});
            OFS_SEC:  model_take(CH_SEC,  d);
            OFS_ASUB: model_take(CH_ASUB, {17'd0, d[SUB_W-1:0]});
            OFS_ASEC: model_take(CH_ASEC, d);
            OFS_CTRL: model_take(CH_CTRL, {28'd0, d[3:0]});
            OFS_STAT: m_err = 1'b0;
            OFS_CLR: begin
                if (d[0]) model_take(CH_CSUB, 32'd1);
                if (d[1]) model_take(CH_CSEC, 32'd1);
            end
            default: ;
        endcase
    endtask

    task automatic model_tick();
        logic ap [NUM_CH];
        logic hit_s, hit_c, top;
        logic [SUB_W-1:0] n_sub;
        logic [SEC_W-1:0] n_sec;
        for (int i = 0; i < NUM_CH; i++) begin
            ap[i] = (m_left[i] == 1);
            if (m_left[i] > 0) m_left[i]--;
        end
        hit_s = (m_sub == m_asub);
        hit_c = (m_sec == m_asec);
        top   = (m_sub >= SUB_W'(WRAP));
        n_sub = m_sub;
        n_sec = m_sec;
        if (m_ctrl[0]) n_sub = top ? '0 : m_sub + 1'b1;
        if (m_ctrl[0] && m_ctrl[1] && top) n_sec = m_sec + 1'b1;
        if (ap[CH_SUB]) n_sub = m_val[CH_SUB][SUB_W-1:0];
        if (ap[CH_SEC]) n_sec = m_val[CH_SEC];
        m_sub = n_sub;
        m_sec = n_sec;
        if (ap[CH_ASUB]) m_asub = m_val[CH_ASUB][SUB_W-1:0];
        if (ap[CH_ASEC]) m_asec = m_val[CH_ASEC];
        if (ap[CH_CTRL]) m_ctrl = m_val[CH_CTRL][3:0];
        m_pend[0] = ap[CH_CSUB] ? 1'b0 : (m_pend[0] | hit_s);
        m_pend[1] = ap[CH_CSEC] ? 1'b0 : (m_pend[1] | hit_c);
    endtask

    task automatic rd_chk(logic [AW-1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic check_all(string tag);
        rd_chk(OFS_SUB,  {17'd0, m_sub},  {tag, " R1 sub counter"});
        rd_chk(OFS_SEC,  m_sec,           {tag, " R1 second counter"});
        rd_chk(OFS_ASUB, {17'd0, m_asub}, {tag, " R1 sub compare"});
        rd_chk(OFS_ASEC, m_asec,          {tag, " R1 second compare"});
        rd_chk(OFS_CTRL, {28'd0, m_ctrl}, {tag, " R1 control"});
        rd_chk(OFS_STAT, exp_stat(),      {tag, " R2 status"});
        rd_chk(OFS_CLR,  32'd0,           {tag, " R1 clear reads zero"});
        chk({tag, " R9 irq"}, {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        model_write(a, d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        model_tick();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic commit(logic [AW-1:0] a, logic [31:0] d, string tag);
        bus_write(a, d);
        check_all({tag, " after write"});
        for (int k = 0; k < 3; k++) begin
            tick();
            check_all({tag, " handover tick"});
        end
    endtask

    task automatic ticks(int n, string tag);
        for (int k = 0; k < n; k++) begin
            tick();
            check_all(tag);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd9137));
        m_sub = '0; m_asub = '0; m_sec = '0; m_asec = '0;
        m_ctrl = '0; m_pend = '0; m_err = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            m_left[i] = 0;
            m_val[i]  = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_all("R10 reset");
        rd_chk(5'h1C, 32'd0, "R10 unmapped read");

        // R7: equal counters and compares at reset set both flags on a tick.
        ticks(1, "R7 match after reset");

        // R2 and R9: enable the sub-second interrupt through the handover.
        commit(OFS_CTRL, 32'h4, "R2 R9 irq enable");

        // R8: move the compare away, then clear each flag.
        commit(OFS_ASUB, 32'd100, "R2 compare load");
        commit(OFS_ASEC, 32'd77, "R2 second compare load");
        commit(OFS_CLR, 32'h1, "R8 clear sub");
        commit(OFS_CLR, 32'h2, "R8 clear second");

        // R3 and R4: overlapping write is refused, error is sticky.
        bus_write(OFS_ASEC, 32'd5);
        bus_write(OFS_ASEC, 32'd9);
        check_all("R3 overlap error");
        bus_write(OFS_SEC, 32'd10);
        check_all("R3 other register no error change");
        ticks(3, "R3 first write kept");
        bus_write(OFS_CTRL, 32'h4);
        ticks(3, "R4 error sticky");
        bus_write(OFS_STAT, 32'd0);
        check_all("R4 status write clears");
        bus_write(5'h1C, 32'hFFFF_FFFF);
        check_all("R10 unmapped write ignored");

        // R6: wrap with second counting enabled.
        commit(OFS_SUB, 32'd32765, "R6 preload");
        commit(OFS_CTRL, 32'h3, "R11 enable both");
        ticks(4, "R6 wrap increments second");

        // R11: counter write overrides counting on its tick.
        commit(OFS_SUB, 32'd97, "R11 write over count");
        ticks(5, "R7 compare match while counting");

        // R5: only sub counting; second holds on wrap.
        commit(OFS_CTRL, 32'hD, "R5 second disabled");
        commit(OFS_SUB, 32'd32766, "R6 preload again");
        ticks(3, "R6 wrap without second");
        commit(OFS_CTRL, 32'h0, "R5 all disabled");
        ticks(3, "R5 hold");

        // Random traffic.
        for (int it = 0; it < 150; it++) begin
            int op = $urandom_range(0, 9);
            logic [31:0] d = $urandom;
            case (op)
                0: bus_write(OFS_SUB, (it % 3 == 0) ? 32'($urandom_range(WRAP - 6, WRAP)) : d);
                1: bus_write(OFS_SEC, d);
                2: bus_write(OFS_ASUB, d);
                3: bus_write(OFS_ASEC, d);
                4: bus_write(OFS_CTRL, d);
                5: bus_write(OFS_CLR, d);
                6: bus_write(OFS_STAT, d);
                7: bus_write(5'h1C, d);
                default: ;
            endcase
            check_all("R3 R4 random write");
            ticks($urandom_range(0, 4), "R5 R6 R7 R8 random ticks");
        end

        finish_run();
    end

endmodule